// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits beside a shared memory that several bus masters reach through one arbitrated port. It follows every transfer as its data phase completes and keeps a single reservation per master: a valid bit and the word-granule address that the master last claimed with an exclusive read. When a master later issues an exclusive write, the block decides at once whether the write may proceed. It reports that decision in the same cycle, beside the write response, and lets the memory see a registered write enable only for writes that are allowed.

Reservations track granules rather than bytes. Any byte address inside an aligned granule of `2**GRAN_BITS` bytes counts as the same location. Any write that actually reaches memory cancels every reservation that covers its granule, including one held by the writer itself. A failed exclusive write never reaches memory, so it cancels no other master's reservation. Bus decoding, arbitration and the memory array sit outside the block.

Top module: `xmon_gate`

## Requirements
- R1: While `rst_n` is low, and afterwards until a new exclusive read, no master holds a reservation. An exclusive write issued straight after reset fails, and `mem_we` is 0 during reset.
- R2: An exclusive read (`xfer_vld`=1, `xfer_wr`=0, `xfer_excl`=1) drives `excl_okay`=1 in its own cycle and reserves its granule for `xfer_mid`. A later exclusive write by that master to the same granule drives `excl_okay`=1 and `excl_fail`=0 in its own cycle.
- R3: An exclusive write fails (`excl_fail`=1, `excl_okay`=0) when its master holds no reservation, or holds one for a different granule.
- R4: A write that reaches memory from another master cancels the reservation. This covers a plain write and a successful exclusive write to the reserved granule. The reserving master's next exclusive write then fails.
- R5: Plain reads from the reserving master, and plain writes to other granules, leave the reservation intact.
- R6: A plain write by the reserving master to its own reserved granule cancels the reservation.
- R7: Every exclusive write, whether it passes or fails, cancels its own master's reservation.
- R8: A new exclusive read replaces the master's earlier reservation. Only the newest granule can pass.
- R9: Granule comparison ignores address bits below `GRAN_BITS` (2 by default), so all byte offsets inside one aligned 4-byte word match.
- R10: `mem_we` is 1 in the cycle after a completed plain write or successful exclusive write, with `mem_addr` holding that write's address. It is 0 after a failed exclusive write, after a read, and after an idle cycle.
- R11: `excl_okay` and `excl_fail` are never 1 together, and both are 0 unless an exclusive transfer completes in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| xfer_vld | input | 1 | A transfer's data phase completes this cycle |
| xfer_wr | input | 1 | 1 = write, 0 = read |
| xfer_excl | input | 1 | Transfer is exclusive |
| xfer_mid | input | MID_W | Issuing master number |
| xfer_addr | input | ADDR_W | Byte address of the transfer |
| excl_okay | output | 1 | Exclusive transfer succeeds (same cycle) |
| excl_fail | output | 1 | Exclusive write fails (same cycle) |
| mem_we | output | 1 | Registered memory write enable |
| mem_addr | output | ADDR_W | Registered address for `mem_we` |

## Verification
Reservation state cannot be seen directly at the ports. The only place a wrong valid bit or a stale granule shows up is the pass/fail flags of that master's next exclusive write, and, one cycle later, `mem_we` being set or held back. The bench therefore drives each scenario through to an exclusive write. It compares the same-cycle flags and the following cycle's enable and address against a reference model of all reservations. Random traffic over a few colliding granules and byte offsets lets a cancellation that should not have happened, or one that was missed, reach a checked exclusive write within a few transfers.

// File: rtl/xmon_gate.sv
module xmon_gate #(
  parameter int N_MST     = 4,
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 2,
  parameter int MID_W     = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_vld,
  input  logic              xfer_wr,
  input  logic              xfer_excl,
  input  logic [MID_W-1:0]  xfer_mid,
  input  logic [ADDR_W-1:0] xfer_addr,
  output logic              excl_okay,
  output logic              excl_fail,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr
);
  localparam int TAG_W = ADDR_W - GRAN_BITS;

  logic [N_MST-1:0] rsv_v;
  logic [TAG_W-1:0] rsv_tag [N_MST];
  logic [TAG_W-1:0] cur_tag;
  logic             own_hit;
  logic             is_xw, is_xr, commit;

  assign cur_tag = xfer_addr[ADDR_W-1:GRAN_BITS];
  assign is_xw   = xfer_vld & xfer_wr & xfer_excl;
  assign is_xr   = xfer_vld & ~xfer_wr & xfer_excl;

  always_comb begin
    own_hit = 1'b0;
    for (int i = 0; i < N_MST; i++)
      if (xfer_mid == MID_W'(i) && rsv_v[i] && rsv_tag[i] == cur_tag) own_hit = 1'b1;
  end

  assign excl_fail = is_xw & ~own_hit;
  assign excl_okay = is_xr | (is_xw & own_hit);
  assign commit    = xfer_vld & xfer_wr & ~excl_fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsv_v    <= '0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
    end else begin
      mem_we <= commit;
      if (commit) mem_addr <= xfer_addr;
      for (int i = 0; i < N_MST; i++) begin
        if (commit && rsv_tag[i] == cur_tag) rsv_v[i] <= 1'b0;
        if (xfer_mid == MID_W'(i) && is_xw) rsv_v[i] <= 1'b0;
        if (xfer_mid == MID_W'(i) && is_xr) rsv_v[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_MST; i++)
      if (xfer_mid == MID_W'(i) && is_xr) rsv_tag[i] <= cur_tag;
  end

  // R11: flags exclusive and only on completed exclusive transfers
  always_comb begin
    if (rst_n) p_flags_onehot_r11: assert (!(excl_okay && excl_fail));
  end

  p_flags_need_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (excl_okay || excl_fail) |-> (xfer_vld && xfer_excl));

  p_fail_blocks_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
    excl_fail |=> !mem_we);

  p_pass_sets_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (excl_okay && xfer_wr) |=> (mem_we && mem_addr == $past(xfer_addr)));

  p_we_from_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(xfer_vld && xfer_wr));
endmodule

// File: tb/xmon_gate_test.sv
`timescale 1ns/1ps
module xmon_gate_test;
  logic clk = 0, rst_n = 0;
  logic xfer_vld = 0, xfer_wr = 0, xfer_excl = 0;
  logic [1:0] xfer_mid = 0;
  logic [31:0] xfer_addr = 0;
  logic excl_okay, excl_fail, mem_we;
  logic [31:0] mem_addr;
  int n_run = 0, n_bad = 0;
  bit done = 0;
  bit ref_v [4];
  logic [29:0] ref_t [4];

  always #2 clk = ~clk;

  xmon_gate uut (.clk, .rst_n, .xfer_vld, .xfer_wr, .xfer_excl, .xfer_mid,
                 .xfer_addr, .excl_okay, .excl_fail, .mem_we, .mem_addr);

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit exp_hit(int m, logic [31:0] a);
    return ref_v[m] && ref_t[m] == a[31:2];
  endfunction

  task automatic xfer(int m, bit wr, bit ex, logic [31:0] a, string tag);
    bit hit, ef, eo, cm;
    @(negedge clk);
    xfer_vld = 1; xfer_wr = wr; xfer_excl = ex; xfer_mid = m[1:0]; xfer_addr = a;
    #1;
    hit = exp_hit(m, a);
    ef = wr & ex & !hit;
    eo = ex & (!wr | hit);
    cm = wr & !ef;
    chk(excl_okay == eo, {tag, " R11 okay"}, 32'(excl_okay), 32'(eo));
    chk(excl_fail == ef, {tag, " R11 fail"}, 32'(excl_fail), 32'(ef));
    if (cm) for (int i = 0; i < 4; i++) if (ref_t[i] == a[31:2]) ref_v[i] = 0;
    if (wr && ex) ref_v[m] = 0;
    if (!wr && ex) begin ref_v[m] = 1; ref_t[m] = a[31:2]; end
    @(negedge clk);
    xfer_vld = 0;
    chk(mem_we == cm, {tag, " R10 we"}, 32'(mem_we), 32'(cm));
    if (cm) chk(mem_addr == a, {tag, " R10 addr"}, mem_addr, a);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin ref_v[i] = 0; ref_t[i] = '0; end
    repeat (3) @(negedge clk);
    chk(mem_we == 0, "R1 reset we", 32'(mem_we), 0);
    @(posedge clk); #1 rst_n = 1;
    xfer(0, 1, 1, 32'h1000, "R1 post-reset xw");
    xfer(0, 0, 1, 32'h1000, "R2 xr");
    xfer(0, 0, 0, 32'h1000, "R5 own read");
    xfer(0, 1, 0, 32'h1008, "R5 other granule write");
    xfer(0, 1, 1, 32'h1003, "R2 R9 xw pass");
    xfer(0, 1, 1, 32'h1000, "R7 repeat xw");
    xfer(1, 0, 1, 32'h1010, "R4 xr");
    xfer(2, 1, 0, 32'h1012, "R4 foreign write");
    xfer(1, 1, 1, 32'h1010, "R4 xw after foreign");
    xfer(1, 0, 1, 32'h1010, "R6 xr");
    xfer(1, 1, 0, 32'h1011, "R6 own write");
    xfer(1, 1, 1, 32'h1010, "R6 xw after own");
    xfer(2, 0, 1, 32'h1020, "R8 xr a");
    xfer(2, 0, 1, 32'h1030, "R8 xr b");
    xfer(2, 1, 1, 32'h1030, "R8 xw newest");
    xfer(2, 0, 1, 32'h1020, "R8 xr a2");
    xfer(2, 0, 1, 32'h1030, "R8 xr b2");
    xfer(2, 1, 1, 32'h1020, "R8 xw stale");
    xfer(3, 0, 1, 32'h1040, "R3 xr");
    xfer(3, 1, 1, 32'h1044, "R3 xw mismatch");
    xfer(0, 0, 1, 32'h1050, "R4 xr m0");
    xfer(1, 0, 1, 32'h1052, "R4 xr m1");
    xfer(1, 1, 1, 32'h1051, "R4 m1 xw pass");
    xfer(0, 1, 1, 32'h1050, "R4 m0 xw lost");
    void'($urandom(32'h5eed));
    for (int k = 0; k < 600; k++) begin
      int m = $urandom_range(0, 3);
      bit wr = $urandom_range(0, 1);
      bit ex = $urandom_range(0, 2) != 0;
      logic [31:0] a = 32'h2000 + 32'($urandom_range(0, 3) * 4) + 32'($urandom_range(0, 3));
      xfer(m, wr, ex, a, "R2/R3/R4/R5/R6/R7 random");
    end
    @(negedge clk);
    chk(mem_we == 0, "R10 idle we", 32'(mem_we), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule